// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Data Channel

This block is a clocked model of a data channel in which each bit travels on two wires, so that the wires carry both the bit's value and whether the bit is present. A sending half accepts a word over a valid/ready interface and puts it on the rails. A receiving half detects from the rails alone when every bit has arrived and raises an acknowledge. The sender then returns every rail to the empty code, and the receiver drops the acknowledge. Only after that does the next word start, so every transfer runs through four phases.

The rail bus leaves the block on one port and comes back in on another, with acknowledge treated the same way. The parent wires the two halves together, or places a channel between them. The receiver hands each decoded word on through a valid/ready output once the return to empty has finished. A saturating counter adds up every rail toggle seen at the receiver, as an estimate of switching activity. A pair of rails that shows both wires high is illegal and sets an error flag that only reset clears.

Top module: `dr_channel`

## Requirements
- R1: For data bit i, rail bit 2i+1 is the zero rail and rail bit 2i is the one rail. A bit of value 0 drives pair code 2'b10, a bit of value 1 drives 2'b01, and 2'b00 is the empty code. The sender's rails carry the encoded word in the cycle after `in_valid && in_ready`.
- R2: After reset the rails are all zero, and `ack_o`, `out_valid` and `err` are 0. `in_ready` is 1 and `activity` is 0.
- R3: `ack_o` rises one cycle after `rails_i` holds a data code (exactly one wire high) on every pair. It never rises at any other time.
- R4: `ack_o` falls one cycle after `rails_i` is all zero while `ack_o` is high, and not before.
- R5: The sender holds its rails unchanged while it sees acknowledge high, except to return them to all zero. It drives zero in the cycle after it sees `ack_i` high. `in_ready` stays low from acceptance until the sender has seen `ack_i` low again.
- R6: The decoded word appears on `out_data` with `out_valid` in the same cycle that `ack_o` falls. Both are held until a cycle with `out_ready` high.
- R7: While an undelivered word is held on the output, the receiver does not acknowledge a new word. It acknowledges one cycle after the held word is taken.
- R8: Any pair on `rails_i` at 2'b11 sets `err` on the next cycle. `err` stays set until reset, and an illegal pair never causes an acknowledge.
- R9: `activity` grows by the number of `rails_i` wires that changed since the previous cycle. A complete transfer of a DATA_W-bit word adds 2*DATA_W.
- R10: `activity` saturates at its all-ones value and never wraps.
- R11: A rail bus on which only some pairs hold data does not cause an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sender word offered |
| in_ready | output | 1 | Sender can take a word |
| in_data | input | DATA_W | Word to send |
| rails_o | output | 2*DATA_W | Sender rail bus |
| ack_i | input | 1 | Acknowledge seen by the sender |
| rails_i | input | 2*DATA_W | Rail bus seen by the receiver |
| ack_o | output | 1 | Receiver acknowledge |
| out_valid | output | 1 | Decoded word available |
| out_ready | input | 1 | Consumer takes the decoded word |
| out_data | output | DATA_W | Decoded word |
| err | output | 1 | Sticky illegal-code flag |
| activity | output | ACT_W | Saturating rail toggle count |

## Verification
The bench builds the block with DATA_W = 8 and ACT_W = 6. The narrow counter tops out at 63, so a fourth complete byte transfer, worth 64 toggles in all, pushes it into saturation. The bench can therefore observe the clamp directly, which a 32-bit counter would put far out of reach. With an 8-bit word the bench can also write whole rail patterns by hand, covering a partly arrived word and an illegal pair placed among otherwise valid pairs.

// File: rtl/dr_pkg.sv
package dr_pkg;

  localparam logic [1:0] PAIR_EMPTY = 2'b00;
  localparam logic [1:0] PAIR_ZERO  = 2'b10;
  localparam logic [1:0] PAIR_ONE   = 2'b01;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_DRIVE = 2'd1,
    TX_RTZ   = 2'd2
  } tx_state_t;

  function automatic logic [1:0] bit_to_pair(input logic b);
    return b ? PAIR_ONE : PAIR_ZERO;
  endfunction

  function automatic logic pair_has_data(input logic [1:0] p);
    return p[1] ^ p[0];
  endfunction

  function automatic logic pair_is_bad(input logic [1:0] p);
    return p[1] & p[0];
  endfunction

  function automatic logic pair_value(input logic [1:0] p);
    return p[0];
  endfunction

endpackage

// File: rtl/dr_sender.sv
module dr_sender
  import dr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RAIL_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack_i,
  output logic [RAIL_W-1:0] rails_o
);

  tx_state_t          state_q;
  logic [RAIL_W-1:0]  enc;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      enc[2*i +: 2] = bit_to_pair(in_data[i]);
    end
  end

  assign in_ready = (state_q == TX_IDLE) && !ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      rails_o <= '0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (in_valid && in_ready) begin
            rails_o <= enc;
            state_q <= TX_DRIVE;
          end
        end
        TX_DRIVE: begin
          if (ack_i) begin
            rails_o <= '0;
            state_q <= TX_RTZ;
          end
        end
        TX_RTZ: begin
          if (!ack_i) state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dr_receiver.sv
module dr_receiver
  import dr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RAIL_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RAIL_W-1:0] rails_i,
  output logic              ack_o,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              err,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_bad
);

  logic [DATA_W-1:0] dec;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    rx_full = 1'b1;
    rx_bad  = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      rx_full = rx_full & pair_has_data(rails_i[2*i +: 2]);
      rx_bad  = rx_bad  | pair_is_bad(rails_i[2*i +: 2]);
      dec[i]  = pair_value(rails_i[2*i +: 2]);
    end
    rx_empty = (rails_i == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      hold_q    <= '0;
      err       <= 1'b0;
    end else begin
      if (rx_bad) err <= 1'b1;
      if (!ack_o) begin
        if (rx_full && !out_valid) begin
          ack_o  <= 1'b1;
          hold_q <= dec;
        end
      end else if (rx_empty) begin
        ack_o     <= 1'b0;
        out_valid <= 1'b1;
        out_data  <= hold_q;
      end
      if (out_valid && out_ready) out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dr_activity.sv
module dr_activity #(
  parameter int RAIL_W = 16,
  parameter int ACT_W  = 32,
  localparam int STEP_W = $clog2(RAIL_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RAIL_W-1:0] rails_i,
  output logic [ACT_W-1:0]  activity
);

  logic [RAIL_W-1:0] prev_q;
  logic [STEP_W-1:0] step;
  logic [ACT_W:0]    sum;

  always_comb begin
    step = '0;
    for (int i = 0; i < RAIL_W; i++) begin
      step = step + STEP_W'(prev_q[i] ^ rails_i[i]);
    end
    sum = {1'b0, activity} + (ACT_W + 1)'(step);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      activity <= '0;
    end else begin
      prev_q <= rails_i;
      if (sum[ACT_W]) activity <= '1;
      else            activity <= sum[ACT_W-1:0];
    end
  end

endmodule

// File: rtl/dr_channel.sv
module dr_channel #(
  parameter int DATA_W = 8,
  parameter int ACT_W  = 32,
  localparam int RAIL_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [RAIL_W-1:0] rails_o,
  input  logic              ack_i,
  input  logic [RAIL_W-1:0] rails_i,
  output logic              ack_o,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              err,
  output logic [ACT_W-1:0]  activity
);

  logic rx_full;
  logic rx_empty;
  logic rx_bad;

  dr_sender #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ack_i(ack_i), .rails_o(rails_o)
  );

  dr_receiver #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .rails_i(rails_i), .ack_o(ack_o),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .err(err), .rx_full(rx_full), .rx_empty(rx_empty), .rx_bad(rx_bad)
  );

  dr_activity #(.RAIL_W(RAIL_W), .ACT_W(ACT_W)) u_act (
    .clk(clk), .rst(rst), .rails_i(rails_i), .activity(activity)
  );

endmodule

// File: rtl/dr_channel_chk.sv
module dr_channel_chk #(
  parameter int DATA_W = 8,
  parameter int ACT_W  = 32,
  localparam int RAIL_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [RAIL_W-1:0] rails_o,
  input logic              ack_i,
  input logic              ack_o,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              err,
  input logic [ACT_W-1:0]  activity,
  input logic              rx_full,
  input logic              rx_empty,
  input logic              rx_bad
);

  a_r3_ack_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(rx_full));

  a_r4_drop_needs_empty: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> $past(rx_empty));

  a_r5_tx_holds: assert property (@(posedge clk) disable iff (rst)
    $past(ack_i) |-> (rails_o == $past(rails_o) || rails_o == '0));

  a_r6_out_held: assert property (@(posedge clk) disable iff (rst)
    $past(out_valid && !out_ready) |-> (out_valid && $stable(out_data)));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(err) |-> err);

  a_r8_no_ack_on_bad: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> !$past(rx_bad));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    activity >= $past(activity));

endmodule

bind dr_channel dr_channel_chk #(.DATA_W(DATA_W), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst(rst), .rails_o(rails_o), .ack_i(ack_i), .ack_o(ack_o),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .err(err), .activity(activity), .rx_full(rx_full), .rx_empty(rx_empty),
  .rx_bad(rx_bad)
);

// File: tb/sim_dr_channel.sv
`timescale 1ns/1ps
module sim_dr_channel;

  localparam int DW = 8;
  localparam int AW = 6;
  localparam int RW = 2 * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [RW-1:0] rails_o;
  logic          ack_i;
  logic [RW-1:0] rails_i;
  logic          ack_o;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          err;
  logic [AW-1:0] activity;

  logic          man_en = 1'b0;
  logic [RW-1:0] man_rails = '0;

  int n_total = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  assign ack_i   = ack_o;
  assign rails_i = man_en ? man_rails : rails_o;

  dr_channel #(.DATA_W(DW), .ACT_W(AW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rails_o(rails_o), .ack_i(ack_i), .rails_i(rails_i),
    .ack_o(ack_o), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .err(err), .activity(activity)
  );

  function automatic logic [RW-1:0] model_rails(input logic [DW-1:0] d);
    logic [RW-1:0] r = '0;
    for (int b = 0; b < DW; b++) begin
      if (d[b]) r[2*b]   = 1'b1;
      else      r[2*b+1] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 rails", 32'(rails_o), 0);
    check("R2 ack", 32'(ack_o), 0);
    check("R2 in_ready", 32'(in_ready), 1);
    check("R2 out_valid", 32'(out_valid), 0);
    check("R2 err", 32'(err), 0);
    check("R2 activity", 32'(activity), 0);
  endtask

  task automatic t_word(input logic [DW-1:0] d, input bit consume);
    @(negedge clk);
    check("R5 ready before", 32'(in_ready), 1);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 encode", 32'(rails_o), 32'(model_rails(d)));
    check("R3 no early ack", 32'(ack_o), 0);
    @(negedge clk);
    check("R3 ack rise", 32'(ack_o), 1);
    check("R5 busy", 32'(in_ready), 0);
    @(negedge clk);
    check("R5 rtz", 32'(rails_o), 0);
    check("R4 ack held", 32'(ack_o), 1);
    check("R6 not yet", 32'(out_valid), 0);
    @(negedge clk);
    check("R4 ack fall", 32'(ack_o), 0);
    check("R6 valid", 32'(out_valid), 1);
    check("R6 data", 32'(out_data), 32'(d));
    @(negedge clk);
    check("R5 ready again", 32'(in_ready), 1);
    if (consume) begin
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check("R6 taken", 32'(out_valid), 0);
    end
  endtask

  task automatic t_backpressure(input logic [DW-1:0] w1, input logic [DW-1:0] w2);
    t_word(w1, 1'b0);
    in_valid = 1'b1;
    in_data  = w2;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R7 blocked ack", 32'(ack_o), 0);
      check("R6 held data", 32'(out_data), 32'(w1));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R6 taken", 32'(out_valid), 0);
    @(negedge clk);
    check("R7 ack after take", 32'(ack_o), 1);
    @(negedge clk);
    @(negedge clk);
    check("R7 second valid", 32'(out_valid), 1);
    check("R7 second data", 32'(out_data), 32'(w2));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_partial();
    man_en    = 1'b1;
    man_rails = 16'h0002;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11 no ack", 32'(ack_o), 0);
    end
    man_rails = '0;
    repeat (2) @(negedge clk);
    check("R11 no output", 32'(out_valid), 0);
  endtask

  task automatic t_illegal();
    man_en    = 1'b1;
    man_rails = 16'hAAEA;
    @(negedge clk);
    check("R8 err set", 32'(err), 1);
    repeat (2) @(negedge clk);
    check("R8 no ack", 32'(ack_o), 0);
    man_rails = '0;
    repeat (3) @(negedge clk);
    check("R8 err sticky", 32'(err), 1);
    man_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_word(8'hA5, 1'b1);
    check("R9 one word", 32'(activity), 16);
    t_word(8'h3C, 1'b1);
    check("R9 two words", 32'(activity), 32);
    check("R8 no spurious err", 32'(err), 0);
    t_backpressure(8'hFF, 8'h00);
    check("R10 saturate", 32'(activity), 63);
    t_partial();
    t_illegal();
    check("R10 stays max", 32'(activity), 63);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule